// File: doc/BRIEF.md
# Atomic Request Transaction Grouper

This block takes one atomic memory instruction from a warp and turns its per-lane accesses into a list of candidate memory transactions. The inputs are a per-lane active mask, one byte address per lane and a two-bit access size code. The warp is cut into a fixed number of subwarps. The atomic path has its own subwarp count and does not share the one used by ordinary loads and stores. Subwarps are handled one after another, and each starts with an empty transaction table.

Inside a subwarp, the active lanes are scanned in ascending order, one lane per clock. Each lane's access is reduced to an aligned segment address and a byte mask within that segment. The lane then joins the oldest transaction of the same segment whose byte mask does not collide with its own bytes. If no such transaction exists, a new entry is opened. Two lanes that touch the same bytes therefore always end up in separate transactions, which keeps every atomic update distinct.

When a subwarp's scan ends, the finished records are streamed over a valid/ready port to a downstream merger, in the order they were created. If the table fills while a lane still needs a fresh entry, the block stalls. It drains what it holds and then resumes with that same lane.

Top module: `atg_grouper`

## Requirements
- R1: The warp of LANES lanes is split into PARTS subwarps of LANES/PARTS consecutive lanes, handled in ascending order. Every record carries its subwarp index on `rec_part` and holds only lanes of that subwarp.
- R2: The size code selects the access size and the segment size. Code 0 is 1 byte in a 32-byte segment, 1 is 2 bytes in 32, 2 is 4 bytes in 64, and 3 is 8 bytes in 128. A record's segment address is the lane address with the low log2(segment size) bits cleared.
- R3: A lane whose first and last byte fall in different segments produces a one-cycle `straddle_err` pulse and appears in no record.
- R4: Inactive lanes are ignored. Active lanes are placed in ascending lane order. A lane joins the earliest-created entry of its segment whose byte mask shares no bit with the lane's bytes; otherwise a new entry is created.
- R5: In `rec_bytes`, bit k stands for the byte at offset k from the segment address. It is the union of the member lanes' bytes. `rec_chunks` bit j is set when any byte at offsets 32*j to 32*j+31 is set.
- R6: In `rec_lanes`, bit i is set exactly when warp lane i is a member of the transaction.
- R7: Once a subwarp's scan ends, its records are presented in creation order with `rec_valid`. Each is accepted on a cycle where `rec_ready` is high, and every record field stays stable while `rec_valid` is high and `rec_ready` is low.
- R8: When DEPTH entries are held and a lane needs a new entry, `stall` goes high. All held records are emitted and the table is cleared. The scan then resumes with the same lane, and `stall` drops.
- R9: A `start` pulse while `busy` is low latches the inputs and raises `busy`. A `start` while `busy` is high is ignored. `done` pulses for one cycle after the final subwarp's last record, in the same cycle that `busy` drops.
- R10: A subwarp with no active lanes emits no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a warp; sampled only when idle |
| lane_active | input | LANES | Per-lane active bits |
| lane_addr | input | LANES*ADDR_W | Lane i address in bits [i*ADDR_W +: ADDR_W] |
| size_code | input | 2 | Access size code (see R2) |
| busy | output | 1 | A warp is being processed |
| rec_valid | output | 1 | A transaction record is offered |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_seg | output | ADDR_W | Aligned segment address |
| rec_bytes | output | 128 | Byte mask within the segment |
| rec_chunks | output | 128/CHUNK_B | 32-byte chunk mask |
| rec_lanes | output | LANES | Member lanes |
| rec_part | output | max(1,log2 PARTS) | Subwarp index of the record |
| stall | output | 1 | Table-full drain in progress |
| straddle_err | output | 1 | A lane crossed a segment boundary |
| done | output | 1 | Warp finished |

## Verification
The assertions assume the downstream side only ever pulls `rec_ready`. They also assume `start` is never raised mid-warp in the expectation that it takes effect. The bench drives `start` only while idle, except in one deliberate case that checks R9. Addresses are kept in a small window so that segment sharing, byte collisions, straddles and table overflow all occur often. The bench runs its own copy of the placement rules and computes the records that should appear.

// File: rtl/atg_pkg.sv
package atg_pkg;

   // widest segment in bytes (size code 3)
   localparam int unsigned SEG_MAX_B = 128;

   // log2 of segment size for a size code
   function automatic int unsigned seg_log2(input logic [1:0] sc);
      return (sc == 2'd0) ? 32'd5 : (32'(sc) + 32'd4);
   endfunction

   // bytes touched by one lane for a size code
   function automatic int unsigned acc_bytes(input logic [1:0] sc);
      return 32'd1 << sc;
   endfunction

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_SCAN  = 2'd2,
      ST_DRAIN = 2'd3
   } grp_state_e;

endpackage

// File: rtl/atg_lane_pick.sv
module atg_lane_pick #(
   parameter int W  = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  mask,
   output logic          found,
   output logic [IW-1:0] idx
);

   generate
      if (W < 1) begin : g_bad_w
         $error("atg_lane_pick: W must be at least 1");
      end
   endgenerate

   // lowest set bit wins
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (mask[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/atg_lane_decode.sv
module atg_lane_decode
   import atg_pkg::*;
#(
   parameter int AW = 32,
   localparam int SB = SEG_MAX_B,
   localparam int OW = $clog2(SB)
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size_code,
   output logic [AW-1:0] seg_addr,
   output logic [SB-1:0] byte_mask,
   output logic          straddle
);

   generate
      if (AW <= OW) begin : g_bad_aw
         $error("atg_lane_decode: address narrower than largest segment");
      end
   endgenerate

   int unsigned    sh;
   int unsigned    nb;
   logic [AW:0]    first_a;
   logic [AW:0]    last_a;
   logic [AW-1:0]  lo_mask;
   logic [OW-1:0]  off;
   logic [SB-1:0]  ones;

   always_comb begin
      sh        = seg_log2(size_code);
      nb        = acc_bytes(size_code);
      first_a   = {1'b0, addr};
      last_a    = first_a + (AW+1)'(nb - 32'd1);
      straddle  = (first_a >> sh) != (last_a >> sh);
      lo_mask   = AW'((32'd1 << sh) - 32'd1);
      seg_addr  = addr & ~lo_mask;
      off       = addr[OW-1:0] & lo_mask[OW-1:0];
      ones      = (SB'(1) << nb) - SB'(1);
      byte_mask = ones << off;
   end

endmodule

// File: rtl/atg_txn_table.sv
module atg_txn_table
   import atg_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LANES = 32,
   parameter int DEPTH = 16,
   localparam int SB = SEG_MAX_B,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             alloc_en,
   input  logic             join_en,
   input  logic [AW-1:0]    q_seg,
   input  logic [SB-1:0]    q_bytes,
   input  logic [LANES-1:0] q_lane,
   output logic             hit,
   output logic [IW-1:0]    hit_idx,
   output logic             full,
   output logic [CW-1:0]    count,
   input  logic [IW-1:0]    rd_idx,
   output logic [AW-1:0]    rd_seg,
   output logic [SB-1:0]    rd_bytes,
   output logic [LANES-1:0] rd_lanes
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("atg_txn_table: DEPTH must be at least 1");
      end
   endgenerate

   logic [AW-1:0]    seg_r   [DEPTH];
   logic [SB-1:0]    bytes_r [DEPTH];
   logic [LANES-1:0] lanes_r [DEPTH];
   logic [CW-1:0]    cnt_r;
   logic [DEPTH-1:0] match;

   // one comparator per entry
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign match[g] = (CW'(g) < cnt_r) &&
                           (seg_r[g] == q_seg) &&
                           ((bytes_r[g] & q_bytes) == '0);
      end
   endgenerate

   // earliest-created matching entry
   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit     = 1'b1;
            hit_idx = IW'(i);
         end
      end
   end

   assign full  = (cnt_r == CW'(DEPTH));
   assign count = cnt_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_r <= '0;
      end else if (clear) begin
         cnt_r <= '0;
      end else if (alloc_en) begin
         seg_r[IW'(cnt_r)]   <= q_seg;
         bytes_r[IW'(cnt_r)] <= q_bytes;
         lanes_r[IW'(cnt_r)] <= q_lane;
         cnt_r               <= cnt_r + CW'(1);
      end else if (join_en) begin
         bytes_r[hit_idx] <= bytes_r[hit_idx] | q_bytes;
         lanes_r[hit_idx] <= lanes_r[hit_idx] | q_lane;
      end
   end

   assign rd_seg   = seg_r[rd_idx];
   assign rd_bytes = bytes_r[rd_idx];
   assign rd_lanes = lanes_r[rd_idx];

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (cnt_r < CW'(DEPTH)));

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_r <= CW'(DEPTH));

   // R4
   join_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      join_en |-> (hit && !alloc_en));

   // R6
   lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en || join_en) |-> $onehot0(q_lane));

endmodule

// File: rtl/atg_grouper.sv
module atg_grouper
   import atg_pkg::*;
#(
   parameter int LANES   = 32,
   parameter int PARTS   = 2,
   parameter int ADDR_W  = 32,
   parameter int DEPTH   = 16,
   parameter int CHUNK_B = 32,
   localparam int SB  = SEG_MAX_B,
   localparam int NCH = SB / CHUNK_B,
   localparam int PW  = (PARTS > 1) ? $clog2(PARTS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [LANES-1:0]         lane_active,
   input  logic [LANES*ADDR_W-1:0]  lane_addr,
   input  logic [1:0]               size_code,
   output logic                     busy,
   output logic                     rec_valid,
   input  logic                     rec_ready,
   output logic [ADDR_W-1:0]        rec_seg,
   output logic [SB-1:0]            rec_bytes,
   output logic [NCH-1:0]           rec_chunks,
   output logic [LANES-1:0]         rec_lanes,
   output logic [PW-1:0]            rec_part,
   output logic                     stall,
   output logic                     straddle_err,
   output logic                     done
);

   localparam int SW  = LANES / PARTS;
   localparam int SWI = (SW > 1) ? $clog2(SW) : 1;
   localparam int LW  = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW  = $clog2(DEPTH + 1);

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("atg_grouper: LANES must be at least 2");
      end
      if (PARTS < 1 || (LANES % PARTS) != 0) begin : g_bad_parts
         $error("atg_grouper: PARTS must divide LANES");
      end
      if (CHUNK_B < 1 || (SB % CHUNK_B) != 0) begin : g_bad_chunk
         $error("atg_grouper: CHUNK_B must divide the largest segment");
      end
      if (ADDR_W < 8) begin : g_bad_aw
         $error("atg_grouper: ADDR_W must be at least 8");
      end
   endgenerate

   grp_state_e                state_q;
   logic [PW-1:0]             sub_q;
   logic [SW-1:0]             todo_q;
   logic [LANES-1:0]          act_q;
   logic [LANES*ADDR_W-1:0]   addr_q;
   logic [1:0]                sc_q;
   logic [IW-1:0]             rd_q;
   logic                      mid_q;
   logic                      err_q;
   logic                      done_q;

   logic                      pk_found;
   logic [SWI-1:0]            pk_idx;
   logic [LW-1:0]             gidx;
   logic [ADDR_W-1:0]         sel_addr;
   logic [LANES-1:0]          lane_bit;
   logic [ADDR_W-1:0]         dec_seg;
   logic [SB-1:0]             dec_bytes;
   logic                      dec_straddle;

   logic                      t_hit;
   logic [IW-1:0]             t_hit_idx;
   logic                      t_full;
   logic [CW-1:0]             t_count;
   logic                      scan_act;
   logic                      join_en;
   logic                      alloc_en;
   logic                      last_rd;
   logic                      tbl_clear;
   logic                      last_part;

   atg_lane_pick #(.W(SW)) u_pick (
      .mask  (todo_q),
      .found (pk_found),
      .idx   (pk_idx)
   );

   always_comb begin
      gidx     = LW'(int'(sub_q) * SW + int'(pk_idx));
      sel_addr = addr_q[gidx*ADDR_W +: ADDR_W];
      lane_bit = LANES'(1) << gidx;
   end

   atg_lane_decode #(.AW(ADDR_W)) u_dec (
      .addr      (sel_addr),
      .size_code (sc_q),
      .seg_addr  (dec_seg),
      .byte_mask (dec_bytes),
      .straddle  (dec_straddle)
   );

   assign scan_act  = (state_q == ST_SCAN) && pk_found;
   assign join_en   = scan_act && !dec_straddle && t_hit;
   assign alloc_en  = scan_act && !dec_straddle && !t_hit && !t_full;
   assign last_rd   = ((CW'(rd_q) + CW'(1)) == t_count);
   assign tbl_clear = (state_q == ST_DRAIN) && rec_ready && last_rd;
   assign last_part = (sub_q == PW'(PARTS - 1));

   atg_txn_table #(
      .AW    (ADDR_W),
      .LANES (LANES),
      .DEPTH (DEPTH)
   ) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (tbl_clear),
      .alloc_en (alloc_en),
      .join_en  (join_en),
      .q_seg    (dec_seg),
      .q_bytes  (dec_bytes),
      .q_lane   (lane_bit),
      .hit      (t_hit),
      .hit_idx  (t_hit_idx),
      .full     (t_full),
      .count    (t_count),
      .rd_idx   (rd_q),
      .rd_seg   (rec_seg),
      .rd_bytes (rec_bytes),
      .rd_lanes (rec_lanes)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sub_q   <= '0;
         todo_q  <= '0;
         act_q   <= '0;
         addr_q  <= '0;
         sc_q    <= '0;
         rd_q    <= '0;
         mid_q   <= 1'b0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         err_q  <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  act_q   <= lane_active;
                  addr_q  <= lane_addr;
                  sc_q    <= size_code;
                  sub_q   <= '0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               todo_q  <= act_q[int'(sub_q)*SW +: SW];
               state_q <= ST_SCAN;
            end
            ST_SCAN: begin
               if (!pk_found) begin
                  if (t_count != '0) begin
                     rd_q    <= '0;
                     state_q <= ST_DRAIN;
                  end else if (last_part) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     sub_q   <= sub_q + PW'(1);
                     state_q <= ST_LOAD;
                  end
               end else if (dec_straddle) begin
                  err_q          <= 1'b1;
                  todo_q[pk_idx] <= 1'b0;
               end else if (t_hit || !t_full) begin
                  todo_q[pk_idx] <= 1'b0;
               end else begin
                  mid_q   <= 1'b1;
                  rd_q    <= '0;
                  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (rec_ready) begin
                  if (last_rd) begin
                     rd_q <= '0;
                     if (mid_q) begin
                        mid_q   <= 1'b0;
                        state_q <= ST_SCAN;
                     end else if (last_part) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                     end else begin
                        sub_q   <= sub_q + PW'(1);
                        state_q <= ST_LOAD;
                     end
                  end else begin
                     rd_q <= rd_q + IW'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // chunk mask folded out of the byte mask
   generate
      for (genvar j = 0; j < NCH; j++) begin : g_chunk
         assign rec_chunks[j] = |rec_bytes[j*CHUNK_B +: CHUNK_B];
      end
   endgenerate

   assign busy         = (state_q != ST_IDLE);
   assign rec_valid    = (state_q == ST_DRAIN);
   assign rec_part     = sub_q;
   assign stall        = mid_q;
   assign straddle_err = err_q;
   assign done         = done_q;

   logic [LANES-1:0] part_mask;
   assign part_mask = LANES'({SW{1'b1}}) << (int'(rec_part) * SW);

   // R7
   rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_seg) &&
         $stable(rec_bytes) && $stable(rec_lanes) && $stable(rec_part)));

   // R8
   stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> t_full);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy ##1 !done));

   // R1
   rec_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> ((rec_lanes & ~part_mask) == '0));

   // R6
   rec_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> ((rec_lanes != '0) && (rec_bytes != '0)));

endmodule

// File: tb/tb_atg_grouper.sv
`timescale 1ns/1ps
module tb_atg_grouper;

   localparam int LN  = 32;
   localparam int PT  = 2;
   localparam int AW  = 16;
   localparam int DP  = 8;
   localparam int SWB = LN / PT;
   localparam int MX  = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [LN-1:0]   lane_active = '0;
   logic [LN*AW-1:0] lane_addr = '0;
   logic [1:0]      size_code = '0;
   logic            busy;
   logic            rec_valid;
   logic            rec_ready = 1'b1;
   logic [AW-1:0]   rec_seg;
   logic [127:0]    rec_bytes;
   logic [3:0]      rec_chunks;
   logic [LN-1:0]   rec_lanes;
   logic [0:0]      rec_part;
   logic            stall;
   logic            straddle_err;
   logic            done;

   always #10 clk = ~clk;

   atg_grouper #(.LANES(LN), .PARTS(PT), .ADDR_W(AW), .DEPTH(DP), .CHUNK_B(32)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .lane_active(lane_active),
      .lane_addr(lane_addr), .size_code(size_code), .busy(busy),
      .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_seg(rec_seg),
      .rec_bytes(rec_bytes), .rec_chunks(rec_chunks), .rec_lanes(rec_lanes),
      .rec_part(rec_part), .stall(stall), .straddle_err(straddle_err), .done(done)
   );

   int n_chk = 0;
   int n_bad = 0;

   int m_addr [LN];
   logic [AW-1:0]  exp_seg   [MX];
   logic [127:0]   exp_bytes [MX];
   logic [LN-1:0]  exp_lanes [MX];
   int             exp_part  [MX];
   int             exp_n, exp_err;
   bit             exp_stall;

   logic [AW-1:0]  got_seg   [MX];
   logic [127:0]   got_bytes [MX];
   logic [3:0]     got_chk   [MX];
   logic [LN-1:0]  got_lanes [MX];
   int             got_part  [MX];
   int             rcv_n, err_n;
   bit             stall_seen, done_seen, rmode;

   logic [31:0] rs_mon = 32'h9e37_79b9;
   logic [31:0] rs_stim = 32'h1234_5678;

   function automatic logic [31:0] xs(input logic [31:0] v);
      logic [31:0] x = v;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic chk(input bit ok, input string what,
                      input logic [127:0] got, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, got, exp);
      end
   endtask

   // monitor: drive ready, capture accepted records and pulses
   initial begin
      forever begin
         @(negedge clk);
         rs_mon = xs(rs_mon);
         rec_ready = rmode ? rs_mon[3] : 1'b1;
         if (rec_valid && rec_ready && rcv_n < MX) begin
            got_seg[rcv_n]   = rec_seg;
            got_bytes[rcv_n] = rec_bytes;
            got_chk[rcv_n]   = rec_chunks;
            got_lanes[rcv_n] = rec_lanes;
            got_part[rcv_n]  = int'(rec_part);
            rcv_n++;
         end
         if (straddle_err) err_n++;
         if (stall) stall_seen = 1'b1;
         if (done) done_seen = 1'b1;
      end
   end

   // reference placement from the requirements
   task automatic model(input logic [LN-1:0] act, input logic [1:0] sc);
      int nb, sh, tc, hit;
      longint a, e, sg, off;
      logic [AW-1:0]  ts [DP];
      logic [127:0]   tb [DP];
      logic [LN-1:0]  tl [DP];
      logic [127:0]   bm;
      nb = 1 << sc;
      sh = (sc == 2'd0) ? 5 : int'(sc) + 4;
      exp_n = 0; exp_err = 0; exp_stall = 1'b0;
      for (int p = 0; p < PT; p++) begin
         tc = 0;
         for (int l = p*SWB; l < (p+1)*SWB; l++) begin
            if (!act[l]) continue;
            a = longint'(m_addr[l]);
            e = a + nb - 1;
            if ((a >> sh) != (e >> sh)) begin
               exp_err++;
               continue;
            end
            sg = (a >> sh) << sh;
            off = a - sg;
            bm = ((128'd1 << nb) - 128'd1) << off;
            hit = -1;
            for (int j = 0; j < tc; j++)
               if (hit < 0 && ts[j] == AW'(sg) && (tb[j] & bm) == '0) hit = j;
            if (hit >= 0) begin
               tb[hit] = tb[hit] | bm;
               tl[hit] = tl[hit] | (LN'(1) << l);
            end else begin
               if (tc == DP) begin
                  for (int j = 0; j < tc; j++) begin
                     exp_seg[exp_n] = ts[j]; exp_bytes[exp_n] = tb[j];
                     exp_lanes[exp_n] = tl[j]; exp_part[exp_n] = p; exp_n++;
                  end
                  tc = 0;
                  exp_stall = 1'b1;
               end
               ts[tc] = AW'(sg); tb[tc] = bm; tl[tc] = LN'(1) << l; tc++;
            end
         end
         for (int j = 0; j < tc; j++) begin
            exp_seg[exp_n] = ts[j]; exp_bytes[exp_n] = tb[j];
            exp_lanes[exp_n] = tl[j]; exp_part[exp_n] = p; exp_n++;
         end
      end
   endtask

   task automatic run(input logic [LN-1:0] act, input logic [1:0] sc,
                      input bit rrand, input bit poke);
      int w;
      logic [3:0] ec;
      model(act, sc);
      rcv_n = 0; err_n = 0; stall_seen = 1'b0; done_seen = 1'b0; rmode = rrand;
      @(negedge clk);
      lane_active = act;
      size_code = sc;
      for (int l = 0; l < LN; l++) lane_addr[l*AW +: AW] = AW'(m_addr[l]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         lane_active = ~act;
         size_code = sc + 2'd1;
         for (int l = 0; l < LN; l++) lane_addr[l*AW +: AW] = AW'(l * 3 + 1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      w = 0;
      while (!done_seen && w < 5000) begin
         @(posedge clk);
         w++;
      end
      @(negedge clk);
      chk(done_seen, "R9 done pulse seen", 128'(done_seen), 128'd1);
      chk(!busy, "R9 busy low after done", 128'(busy), 128'd0);
      chk(rcv_n == exp_n, "R7 record count", 128'(rcv_n), 128'(exp_n));
      if (poke) chk(rcv_n == exp_n, "R9 start while busy ignored", 128'(rcv_n), 128'(exp_n));
      for (int i = 0; i < rcv_n && i < exp_n; i++) begin
         for (int j = 0; j < 4; j++) ec[j] = |exp_bytes[i][j*32 +: 32];
         chk(got_seg[i] == exp_seg[i], "R2 segment address", 128'(got_seg[i]), 128'(exp_seg[i]));
         chk(got_bytes[i] == exp_bytes[i], "R5 byte mask", got_bytes[i], exp_bytes[i]);
         chk(got_chk[i] == ec, "R5 chunk mask", 128'(got_chk[i]), 128'(ec));
         chk(got_lanes[i] == exp_lanes[i], "R4 R6 lane mask", 128'(got_lanes[i]), 128'(exp_lanes[i]));
         chk(got_part[i] == exp_part[i], "R1 subwarp index", 128'(got_part[i]), 128'(exp_part[i]));
      end
      chk(err_n == exp_err, "R3 straddle pulses", 128'(err_n), 128'(exp_err));
      chk(stall_seen == exp_stall, "R8 stall seen", 128'(stall_seen), 128'(exp_stall));
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int nb;
      logic [LN-1:0] act;
      repeat (5) @(negedge clk);
      chk(!busy && !rec_valid && !stall && !done && !straddle_err,
          "R9 reset state", {busy, rec_valid, stall, done, straddle_err}, 128'd0);
      rst_n = 1'b1;

      // every lane on one word: full conflicts, table overflow (R8, R4)
      for (int l = 0; l < LN; l++) m_addr[l] = 'h40;
      run('1, 2'd2, 1'b0, 1'b0);

      // unit stride per size code, all lanes share segments (R2, R5)
      for (int s = 0; s < 4; s++) begin
         nb = 1 << s;
         for (int l = 0; l < LN; l++) m_addr[l] = 'h100 + l * nb;
         run('1, 2'(s), 1'b1, 1'b0);
      end

      // random aligned addresses with random active masks (R4, R10)
      for (int s = 0; s < 4; s++) begin
         for (int r = 0; r < 4; r++) begin
            nb = 1 << s;
            for (int l = 0; l < LN; l++) begin
               rs_stim = xs(rs_stim);
               m_addr[l] = int'(rs_stim[7:0]) & ~(nb - 1);
            end
            rs_stim = xs(rs_stim);
            act = rs_stim;
            run(act, 2'(s), r[0], 1'b0);
         end
      end

      // unaligned random addresses: straddles appear (R3)
      for (int s = 1; s < 4; s++) begin
         for (int r = 0; r < 3; r++) begin
            for (int l = 0; l < LN; l++) begin
               rs_stim = xs(rs_stim);
               m_addr[l] = int'(rs_stim[8:0]);
            end
            rs_stim = xs(rs_stim);
            act = rs_stim | 32'h0001_0001;
            run(act, 2'(s), 1'b1, 1'b0);
         end
      end

      // single lane crossing a 64-byte boundary (R3)
      for (int l = 0; l < LN; l++) m_addr[l] = 62;
      run(32'h0000_0001, 2'd2, 1'b0, 1'b0);
      chk(rcv_n == 0, "R3 straddling lane absent", 128'(rcv_n), 128'd0);

      // no active lanes (R10)
      run('0, 2'd1, 1'b0, 1'b0);
      chk(rcv_n == 0, "R10 empty warp emits nothing", 128'(rcv_n), 128'd0);

      // only upper subwarp active (R10, R1)
      for (int l = 0; l < LN; l++) m_addr[l] = 'h80 + 2 * l;
      run(32'hFFFF_0000, 2'd1, 1'b1, 1'b0);

      // start pulse during a busy warp (R9)
      for (int l = 0; l < LN; l++) m_addr[l] = 'h40;
      run('1, 2'd3, 1'b1, 1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule